// File: doc/BRIEF.md
# Tuning Command Sequencer

This block is the command controller that sits behind a radio tuner's register file. Software selects a command kind (measurement, oscillator adjustment or radio tuning) in a mode register, writes a 16-bit target value as a low byte followed by a high byte, and the high-byte write launches the command. The sequencer then holds a busy status for the command's nominal duration, counted in ticks of a slow reference enable, and ends with a 2-bit completion code. The analog loops are outside the block. Loop lock, loss of the loop's correction range and DAC-limit events arrive as single-cycle input pulses.

Alongside the command flow the block keeps a tuned flag and an interrupt flag. The interrupt is raised only when tuning is lost. The block also owns the radio-power bit. After reset the bit is forced off after a fixed delay. Each time it is switched on, a settle interval must pass before a command may start. Writing to either of the two read-only identification addresses aborts a running command.

Top module: `tune_cmd_seq`

## Requirements
- R1: The mode register (address 0x13) holds the command kind in bits [1:0] (0 none, 1 measurement, 2 adjustment, 3 tuning) and the band in bit 2 (1 selects the AM tuning duration). A launching write with kind 0 starts nothing.
- R2: A command starts only on a write to the target high byte (0x17) that follows a write to the target low byte (0x16), and only while the radio power is on and settled. Each high-byte write uses up the armed low byte. Target writes are stored even when no command starts.
- R3: While a command runs, status_o reads 3 and busy_o is 1. After MEAS_TICKS, ADJ_TICKS, FM_TICKS or AM_TICKS ticks (chosen by kind and band), the command ends with status 0.
- R4: A DAC-limit pulse during a command ends it at once with status 1.
- R5: A write to address 0x00 or 0x01 during a command ends it with status 2. The same write while idle leaves the status and busy outputs unchanged.
- R6: The tuned flag is set when a tuning command ends with a lock pulse seen during it. The flag is cleared when a new tuning command starts, on a range-loss pulse, or when the radio power goes off.
- R7: irq_o is set in the same cycle in which the tuned flag falls from 1 to 0, and never on a rise of the tuned flag. It stays set until bit 0 of a write to address 0x1E is 1.
- R8: After reset the radio power bit reads 1. It is forced to 0 at the POR_TICKS-th tick.
- R9: The radio power bit is bit 0 of address 0x1F. A 0-to-1 change of this bit starts a settle interval, and cmd_ready_o rises only after SETTLE_TICKS ticks.
- R10: A target high-byte write during a running command neither restarts it nor changes its remaining duration.
- R11: Turning the radio power off during a command ends it with status 2 one cycle after the power bit clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Slow reference tick enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write address |
| wr_data_i | input | 8 | Register write data |
| lock_i | input | 1 | Loop lock pulse |
| range_lost_i | input | 1 | Loop left its correction range (pulse) |
| dac_limit_i | input | 1 | DAC limit reached (pulse) |
| status_o | output | 2 | Completion code: 0 ok, 1 DAC limit, 2 forced end, 3 busy |
| busy_o | output | 1 | Command running |
| tuned_o | output | 1 | Tuned flag |
| irq_o | output | 1 | Tuning-lost interrupt flag |
| radio_pwr_o | output | 1 | Radio power bit |
| cmd_ready_o | output | 1 | Power on and settled |
| target_o | output | 16 | Stored target value |

## Verification
Every result is registered once. A write, tick or event pulse sampled at one rising edge shows on the outputs just after that edge, and the bench samples at the following falling edge. The only exception is a power-off write. Its effect on the command and the tuned flag comes from the registered power bit, so the bench waits one further cycle before checking it. Durations are checked by giving one tick fewer than the duration, checking that the command is still busy, and then giving the last tick.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_MEAS = 2'd1,
    KIND_ADJ  = 2'd2,
    KIND_TUNE = 2'd3
  } cmd_kind_e;

  typedef enum logic [1:0] {
    CODE_OK     = 2'd0,
    CODE_DACLIM = 2'd1,
    CODE_FORCED = 2'd2,
    CODE_BUSY   = 2'd3
  } cmd_code_e;

  // Duration of a command in reference ticks.
  function automatic int unsigned kind_ticks(input cmd_kind_e kind, input logic am_band,
                                             input int unsigned meas_t, input int unsigned adj_t,
                                             input int unsigned fm_t, input int unsigned am_t);
    case (kind)
      KIND_MEAS: return meas_t;
      KIND_ADJ:  return adj_t;
      KIND_TUNE: return am_band ? am_t : fm_t;
      default:   return 0;
    endcase
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/tcs_power.sv
module tcs_power #(
  parameter int unsigned POR_TICKS    = 40,
  parameter int unsigned SETTLE_TICKS = 1200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic pwr_wr_i,
  input  logic pwr_val_i,
  output logic pwr_o,
  output logic ready_o,
  output logic por_fire_o
);
  localparam int POR_W = $clog2(POR_TICKS + 1);
  localparam int STL_W = $clog2(SETTLE_TICKS + 1);

  logic [POR_W-1:0] por_cnt_q;
  logic             por_done_q;
  logic [STL_W-1:0] settle_q;
  logic             pwr_q;
  logic             pwr_nxt;
  logic             pwr_rise;

  assign por_fire_o = !por_done_q && tick_i && (por_cnt_q == POR_W'(1));
  assign pwr_nxt    = por_fire_o ? 1'b0 : (pwr_wr_i ? pwr_val_i : pwr_q);
  assign pwr_rise   = !pwr_q && pwr_nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      por_cnt_q  <= POR_W'(POR_TICKS);
      por_done_q <= 1'b0;
      pwr_q      <= 1'b1;
      settle_q   <= STL_W'(SETTLE_TICKS);
    end else begin
      pwr_q <= pwr_nxt;
      if (!por_done_q && tick_i) begin
        por_cnt_q <= por_cnt_q - POR_W'(1);
        if (por_fire_o) por_done_q <= 1'b1;
      end
      if (pwr_rise) settle_q <= STL_W'(SETTLE_TICKS);
      else if (tick_i && settle_q != '0) settle_q <= settle_q - STL_W'(1);
    end
  end

  assign pwr_o   = pwr_q;
  assign ready_o = pwr_q && (settle_q == '0);

  AST_READY_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> pwr_o); // R9
  AST_POR_CLEARS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    por_fire_o |=> !pwr_o); // R8
  AST_RISE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_o) |-> !ready_o); // R9

endmodule

// File: rtl/tcs_cmd_fsm.sv
module tcs_cmd_fsm
  import tcs_pkg::*;
#(
  parameter int unsigned CNT_W  = 11,
  parameter int unsigned MEAS_T = 134,
  parameter int unsigned ADJ_T  = 540,
  parameter int unsigned FM_T   = 105,
  parameter int unsigned AM_T   = 158
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick_i,
  input  logic      ready_i,
  input  logic      pwr_i,
  input  logic      lo_wr_i,
  input  logic      hi_wr_i,
  input  logic      abort_wr_i,
  input  cmd_kind_e kind_i,
  input  logic      am_i,
  input  logic      dac_lim_i,
  output logic      busy_o,
  output cmd_code_e code_o,
  output logic      tune_launch_o,
  output logic      tune_done_o,
  output logic      tune_active_o
);
  logic             armed_q;
  logic             busy_q;
  logic [CNT_W-1:0] rem_q;
  cmd_kind_e        cur_q;
  cmd_code_e        code_q;

  logic launch_evt, cancel_evt, dac_evt, expire_evt;

  assign launch_evt = hi_wr_i && armed_q && ready_i && !busy_q && (kind_i != KIND_NONE);
  assign cancel_evt = busy_q && (abort_wr_i || !pwr_i);
  assign dac_evt    = busy_q && !cancel_evt && dac_lim_i;
  assign expire_evt = busy_q && !cancel_evt && !dac_evt && tick_i && (rem_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      busy_q  <= 1'b0;
      rem_q   <= '0;
      cur_q   <= KIND_NONE;
      code_q  <= CODE_OK;
    end else begin
      if (lo_wr_i) armed_q <= 1'b1;
      else if (hi_wr_i) armed_q <= 1'b0;
      if (launch_evt) begin
        busy_q <= 1'b1;
        rem_q  <= CNT_W'(kind_ticks(kind_i, am_i, MEAS_T, ADJ_T, FM_T, AM_T));
        cur_q  <= kind_i;
        code_q <= CODE_BUSY;
      end else if (cancel_evt) begin
        busy_q <= 1'b0;
        code_q <= CODE_FORCED;
      end else if (dac_evt) begin
        busy_q <= 1'b0;
        code_q <= CODE_DACLIM;
      end else if (expire_evt) begin
        busy_q <= 1'b0;
        code_q <= CODE_OK;
      end else if (busy_q && tick_i) begin
        rem_q <= rem_q - CNT_W'(1);
      end
    end
  end

  assign busy_o        = busy_q;
  assign code_o        = code_q;
  assign tune_launch_o = launch_evt && (kind_i == KIND_TUNE);
  assign tune_done_o   = expire_evt && (cur_q == KIND_TUNE);
  assign tune_active_o = busy_q && (cur_q == KIND_TUNE);

  AST_START_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(ready_i && hi_wr_i)); // R2
  AST_DAC_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && dac_lim_i && pwr_i && !abort_wr_i) |=> (code_o == CODE_DACLIM && !busy_o)); // R4
  AST_ABORT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && abort_wr_i) |=> (code_o == CODE_FORCED && !busy_o)); // R5
  AST_IDLE_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && abort_wr_i && !hi_wr_i) |=> $stable(code_o)); // R5
  AST_BUSY_HOLDS_REM: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick_i) |=> (busy_q && $stable(rem_q)) || !busy_q); // R10

endmodule

// File: rtl/tcs_tune_flag.sv
module tcs_tune_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_i,
  input  logic tune_launch_i,
  input  logic tune_done_i,
  input  logic tune_active_i,
  input  logic lock_i,
  input  logic range_lost_i,
  input  logic irq_clr_i,
  output logic tuned_o,
  output logic irq_o
);
  logic tuned_q, irq_q, lock_seen_q;
  logic tuned_nxt, tuned_fall;

  always_comb begin
    tuned_nxt = tuned_q;
    if (!pwr_i || tune_launch_i || range_lost_i) tuned_nxt = 1'b0;
    else if (tune_done_i && (lock_seen_q || lock_i)) tuned_nxt = 1'b1;
  end

  assign tuned_fall = tuned_q && !tuned_nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tuned_q     <= 1'b0;
      irq_q       <= 1'b0;
      lock_seen_q <= 1'b0;
    end else begin
      tuned_q <= tuned_nxt;
      irq_q   <= tuned_fall || (irq_q && !irq_clr_i);
      if (tune_launch_i) lock_seen_q <= 1'b0;
      else if (tune_active_i && lock_i) lock_seen_q <= 1'b1;
    end
  end

  assign tuned_o = tuned_q;
  assign irq_o   = irq_q;

  AST_IRQ_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> ($past(tuned_q) && !tuned_q)); // R7
  AST_NO_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tuned_q) |-> !$rose(irq_q)); // R7
  AST_RANGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    range_lost_i |=> !tuned_q); // R6

endmodule

// File: rtl/tune_cmd_seq.sv
module tune_cmd_seq
  import tcs_pkg::*;
#(
  parameter int unsigned AW           = 8,
  parameter int unsigned DW           = 8,
  parameter int unsigned ID0_ADDR     = 8'h00,
  parameter int unsigned ID1_ADDR     = 8'h01,
  parameter int unsigned MODE_ADDR    = 8'h13,
  parameter int unsigned TGT_LO_ADDR  = 8'h16,
  parameter int unsigned TGT_HI_ADDR  = 8'h17,
  parameter int unsigned IRQCLR_ADDR  = 8'h1E,
  parameter int unsigned PWR_ADDR     = 8'h1F,
  parameter int unsigned POR_TICKS    = 40,
  parameter int unsigned SETTLE_TICKS = 1200,
  parameter int unsigned MEAS_TICKS   = 134,
  parameter int unsigned ADJ_TICKS    = 540,
  parameter int unsigned FM_TICKS     = 105,
  parameter int unsigned AM_TICKS     = 158
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          lock_i,
  input  logic          range_lost_i,
  input  logic          dac_limit_i,
  output logic [1:0]    status_o,
  output logic          busy_o,
  output logic          tuned_o,
  output logic          irq_o,
  output logic          radio_pwr_o,
  output logic          cmd_ready_o,
  output logic [2*DW-1:0] target_o
);
  localparam int unsigned MAX_T = max4(MEAS_TICKS, ADJ_TICKS, FM_TICKS, AM_TICKS);
  localparam int unsigned CNT_W = $clog2(MAX_T + 1);

  // Address decode, brought out as named events.
  logic wr_mode, wr_lo, wr_hi, wr_abort, wr_irqclr, wr_pwr;
  assign wr_mode   = wr_en_i && (wr_addr_i == AW'(MODE_ADDR));
  assign wr_lo     = wr_en_i && (wr_addr_i == AW'(TGT_LO_ADDR));
  assign wr_hi     = wr_en_i && (wr_addr_i == AW'(TGT_HI_ADDR));
  assign wr_abort  = wr_en_i && ((wr_addr_i == AW'(ID0_ADDR)) || (wr_addr_i == AW'(ID1_ADDR)));
  assign wr_irqclr = wr_en_i && (wr_addr_i == AW'(IRQCLR_ADDR)) && wr_data_i[0];
  assign wr_pwr    = wr_en_i && (wr_addr_i == AW'(PWR_ADDR));

  cmd_kind_e     kind_q;
  logic          am_q;
  logic [DW-1:0] tgt_lo_q, tgt_hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q   <= KIND_NONE;
      am_q     <= 1'b0;
      tgt_lo_q <= '0;
      tgt_hi_q <= '0;
    end else begin
      if (wr_mode) begin
        kind_q <= cmd_kind_e'(wr_data_i[1:0]);
        am_q   <= wr_data_i[2];
      end
      if (wr_lo) tgt_lo_q <= wr_data_i;
      if (wr_hi) tgt_hi_q <= wr_data_i;
    end
  end

  logic pwr, ready, por_fire;
  logic tune_launch, tune_done, tune_active;
  cmd_code_e code;

  tcs_power #(
    .POR_TICKS   (POR_TICKS),
    .SETTLE_TICKS(SETTLE_TICKS)
  ) i_power (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .pwr_wr_i  (wr_pwr),
    .pwr_val_i (wr_data_i[0]),
    .pwr_o     (pwr),
    .ready_o   (ready),
    .por_fire_o(por_fire)
  );

  tcs_cmd_fsm #(
    .CNT_W (CNT_W),
    .MEAS_T(MEAS_TICKS),
    .ADJ_T (ADJ_TICKS),
    .FM_T  (FM_TICKS),
    .AM_T  (AM_TICKS)
  ) i_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .ready_i      (ready),
    .pwr_i        (pwr),
    .lo_wr_i      (wr_lo),
    .hi_wr_i      (wr_hi),
    .abort_wr_i   (wr_abort),
    .kind_i       (kind_q),
    .am_i         (am_q),
    .dac_lim_i    (dac_limit_i),
    .busy_o       (busy_o),
    .code_o       (code),
    .tune_launch_o(tune_launch),
    .tune_done_o  (tune_done),
    .tune_active_o(tune_active)
  );

  tcs_tune_flag i_flag (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_i        (pwr),
    .tune_launch_i(tune_launch),
    .tune_done_i  (tune_done),
    .tune_active_i(tune_active),
    .lock_i       (lock_i),
    .range_lost_i (range_lost_i),
    .irq_clr_i    (wr_irqclr),
    .tuned_o      (tuned_o),
    .irq_o        (irq_o)
  );

  assign status_o    = code;
  assign radio_pwr_o = pwr;
  assign cmd_ready_o = ready;
  assign target_o    = {tgt_hi_q, tgt_lo_q};

  AST_PWR_OFF_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !radio_pwr_o) |=> (!busy_o && status_o == 2'd2)); // R11
  AST_PWR_OFF_UNTUNED: assert property (@(posedge clk) disable iff (!rst_n)
    !radio_pwr_o |=> !tuned_o); // R6
  AST_NO_START_UNREADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ready_o && !busy_o) |=> !busy_o); // R2
  AST_POR_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    por_fire |=> !cmd_ready_o); // R8

endmodule

// File: tb/test_tune_cmd_seq.sv
module test_tune_cmd_seq;
  localparam int POR = 6, SETTLE = 10, MEAS = 4, ADJ = 7, FM = 5, AM = 8;
  localparam logic [7:0] A_MODE = 8'h13, A_LO = 8'h16, A_HI = 8'h17,
                         A_IRQ = 8'h1E, A_PWR = 8'h1F;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0;
  logic lock = 1'b0, range_lost = 1'b0, dac_lim = 1'b0;
  logic [1:0] status;
  logic busy, tuned, irq, pwr, ready;
  logic [15:0] target;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  tune_cmd_seq #(
    .POR_TICKS(POR), .SETTLE_TICKS(SETTLE), .MEAS_TICKS(MEAS),
    .ADJ_TICKS(ADJ), .FM_TICKS(FM), .AM_TICKS(AM)
  ) i_tune_cmd_seq (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .lock_i(lock), .range_lost_i(range_lost), .dac_limit_i(dac_lim),
    .status_o(status), .busy_o(busy), .tuned_o(tuned), .irq_o(irq),
    .radio_pwr_o(pwr), .cmd_ready_o(ready), .target_o(target)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic pulse_lock();
    @(negedge clk); lock = 1'b1; @(negedge clk); lock = 1'b0;
  endtask

  task automatic launch(input logic [7:0] mode);
    wr(A_MODE, mode); wr(A_LO, 8'h2C); wr(A_HI, 8'h27);
  endtask

  task automatic t_reset();
    check("R8 reset status", status, 0);
    check("R8 reset busy", busy, 0);
    check("R6 reset tuned", tuned, 0);
    check("R7 reset irq", irq, 0);
    check("R8 reset power on", pwr, 1);
    check("R9 reset not ready", ready, 0);
  endtask

  task automatic t_por();
    ticks(POR - 1);
    check("R8 power before delay", pwr, 1);
    ticks(1);
    check("R8 power forced off", pwr, 0);
  endtask

  task automatic t_off_no_start();
    wr(A_MODE, 8'h01); wr(A_LO, 8'h34); wr(A_HI, 8'h12);
    check("R2 no start while off", busy, 0);
    check("R2 target stored while off", target, 16'h1234);
  endtask

  task automatic t_settle();
    wr(A_PWR, 8'h01);
    check("R9 power on", pwr, 1);
    check("R9 not ready at once", ready, 0);
    wr(A_LO, 8'h01); wr(A_HI, 8'h02);
    check("R9 no start during settle", busy, 0);
    ticks(SETTLE - 1);
    check("R9 still settling", ready, 0);
    ticks(1);
    check("R9 ready after settle", ready, 1);
  endtask

  task automatic t_arming();
    wr(A_HI, 8'h05);
    check("R2 high byte alone ignored", busy, 0);
    wr(A_MODE, 8'h00); wr(A_LO, 8'h01); wr(A_HI, 8'h02);
    check("R1 kind none starts nothing", busy, 0);
  endtask

  task automatic t_measure();
    launch(8'h01);
    check("R3 busy code", status, 3);
    check("R3 busy flag", busy, 1);
    ticks(MEAS - 1);
    check("R3 measure still busy", busy, 1);
    ticks(1);
    check("R3 measure done code", status, 0);
    check("R3 measure done busy", busy, 0);
  endtask

  task automatic t_adjust();
    launch(8'h02);
    ticks(ADJ - 1);
    check("R1 adjust duration not over", status, 3);
    ticks(1);
    check("R1 adjust duration over", status, 0);
  endtask

  task automatic t_dac();
    launch(8'h02);
    ticks(2);
    @(negedge clk); dac_lim = 1'b1; @(negedge clk); dac_lim = 1'b0;
    check("R4 dac limit code", status, 1);
    check("R4 dac limit ends", busy, 0);
  endtask

  task automatic t_abort();
    launch(8'h01);
    wr(8'h01, 8'hA5);
    check("R5 abort code", status, 2);
    check("R5 abort ends", busy, 0);
    launch(8'h01); ticks(MEAS);
    wr(8'h00, 8'h3C);
    check("R5 idle abort keeps code", status, 0);
    check("R5 idle abort keeps busy", busy, 0);
  endtask

  task automatic t_hi_busy();
    launch(8'h01);
    ticks(2);
    wr(A_LO, 8'h11); wr(A_HI, 8'h22);
    ticks(MEAS - 3);
    check("R10 still busy", busy, 1);
    ticks(1);
    check("R10 original end kept", busy, 0);
  endtask

  task automatic tune_locked();
    launch(8'h03);
    pulse_lock();
    ticks(FM);
  endtask

  task automatic t_tune();
    launch(8'h03);
    check("R6 tuned clear at start", tuned, 0);
    pulse_lock();
    ticks(FM - 1);
    check("R6 fm tune busy", busy, 1);
    ticks(1);
    check("R6 tuned set", tuned, 1);
    check("R7 no irq on rise", irq, 0);
    launch(8'h07);
    check("R6 new tune clears", tuned, 0);
    check("R7 irq on fall", irq, 1);
    wr(A_IRQ, 8'h00);
    check("R7 clear bit 0 keeps irq", irq, 1);
    wr(A_IRQ, 8'h01);
    check("R7 irq cleared", irq, 0);
    ticks(AM - 1);
    check("R3 am tune busy", busy, 1);
    ticks(1);
    check("R3 am tune done", status, 0);
    check("R6 no lock no tuned", tuned, 0);
  endtask

  task automatic t_range();
    tune_locked();
    check("R6 tuned before loss", tuned, 1);
    @(negedge clk); range_lost = 1'b1; @(negedge clk); range_lost = 1'b0;
    check("R6 range loss clears", tuned, 0);
    check("R7 irq on range loss", irq, 1);
    wr(A_IRQ, 8'h01);
  endtask

  task automatic t_pwr_drop();
    tune_locked();
    launch(8'h01);
    wr(A_PWR, 8'h00);
    @(negedge clk);
    check("R11 power drop code", status, 2);
    check("R11 power drop ends", busy, 0);
    check("R6 power off clears tuned", tuned, 0);
    check("R7 irq on power off", irq, 1);
    check("R9 not ready when off", ready, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset(); t_por(); t_off_no_start(); t_settle(); t_arming();
        t_measure(); t_adjust(); t_dac(); t_abort(); t_hi_busy();
        t_tune(); t_range(); t_pwr_drop();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule